// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command front end of a byte-wide flash array. It watches single-cycle bus writes (address, data, write strobe) and recognises command sequences that each open with a fixed two-write unlock prefix. The supported commands are byte program, chip erase, sector erase and a read/reset that only returns the decoder to idle. A completed command launches an embedded-operation engine. The engine is a busy counter that also performs the array update. While it runs, reads return a polling status byte in place of array data.

Sector erase commands are gathered inside a timed window. Each further sector-erase write adds its sector and restarts the window, and erasure of the whole set begins only once the window expires. The storage is a small register file. Each sector keeps only its lowest CELL_W address bits, so addresses that differ only in the middle bits share a cell. Reads are synchronous, and the byte for the address presented at a clock edge appears after that edge.

Top module: `flash_cmd_if`

## Requirements
- R1: Every command starts with data AAh written to command address 5555h, followed by data 55h written to command address 2AAAh. Command address matching compares only address bits 14..0, so bits 16 and 15 are ignored there.
- R2: After the prefix, writing A0h to 5555h and then one write carrying the target address and data programs that byte. The stored value becomes old AND new, so a bit at 0 never returns to 1.
- R3: After the prefix, writing F0h to 5555h starts no operation and leaves the array unchanged, and the decoder returns to idle.
- R4: The six-write sequence prefix, 80h/5555h, AAh/5555h, 55h/2AAAh, 10h/5555h sets every byte of the array to FFh.
- R5: The same five writes followed by 30h to any address marks the sector given by address bits 16..14 for erase. Only marked sectors become FFh, and all other sectors keep their contents.
- R6: The erase window lasts WIN_CYC = CLK_HZ/1e6 × WIN_US cycles from the edge that captures the last 30h write, and erasure starts at the edge that ends it. A 30h write inside the window, to any address, adds that sector and restarts the full window.
- R7: While the engine runs, every write has no effect. While the erase window is open, every write other than data 30h has no effect.
- R8: A write that does not match the next expected step of a sequence returns the decoder to idle with no operation started and no error.
- R9: While busy, a read returns a status byte. Bit 7 is the complement of bit 7 of the byte being programmed, and it is 0 during erase or the erase window. Bit 3 is 1 only while the erase window is open. All other bits are 0. After the operation ends, reads return array data again.
- R10: `busy` is 0 in reset and rises in the cycle after the write that starts an operation or opens the erase window. It stays high until the operation ends.
- R11: `rd_data` holds the array byte for the address that `bus_addr` carried at the previous clock edge, so reads of different addresses in back-to-back cycles each return their own byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| rd_data | output | 8 | Array byte or polling status, one cycle after the address |
| busy | output | 1 | Operation running or erase window open |

## Verification
The assertions assume that `bus_we` marks each bus write for exactly one cycle, with address and data valid in that cycle. They also assume that no write is presented while `rst` is high. The bench drives every write through one task that raises the strobe for a single edge. It keeps the address stable across each read edge, and it starts with a chip erase so that no check depends on the array's undefined power-up contents. The window length is shortened through WIN_US so that the exact expiry edge and a restart inside the window can both be observed at the ports.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] ADR_KEY_A = 15'h5555;
  localparam logic [CMP_W-1:0] ADR_KEY_B = 15'h2AAA;

  localparam logic [7:0] DAT_KEY_A   = 8'hAA;
  localparam logic [7:0] DAT_KEY_B   = 8'h55;
  localparam logic [7:0] DAT_RESET   = 8'hF0;
  localparam logic [7:0] DAT_PROG    = 8'hA0;
  localparam logic [7:0] DAT_ERASE   = 8'h80;
  localparam logic [7:0] DAT_CHIP    = 8'h10;
  localparam logic [7:0] DAT_SECTOR  = 8'h30;

  typedef enum logic [2:0] {
    S_IDLE,
    S_KEY1,
    S_KEY2,
    S_PROG,
    S_ER_KEY0,
    S_ER_KEY1,
    S_ER_LAST
  } seq_state_t;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_P_RD,
    ENG_P_WR,
    ENG_WAIT,
    ENG_ERASE
  } eng_state_t;

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lock,
  input  logic             we,
  input  logic [CMP_W-1:0] cmp_addr,
  input  logic [7:0]       data,
  output logic             start_prog,
  output logic             start_chip,
  output logic             sect_req
);

  seq_state_t st;
  logic hit_a, hit_b, wr_ok;

  assign hit_a = (cmp_addr == ADR_KEY_A);
  assign hit_b = (cmp_addr == ADR_KEY_B);
  assign wr_ok = we && !lock;

  assign start_prog = wr_ok && (st == S_PROG);
  assign start_chip = wr_ok && (st == S_ER_LAST) && hit_a && (data == DAT_CHIP);
  assign sect_req   = wr_ok && (st == S_ER_LAST) && (data == DAT_SECTOR);

  always_ff @(posedge clk) begin
    if (rst || lock) begin
      st <= S_IDLE;
    end else if (we) begin
      unique case (st)
        S_IDLE:    st <= (hit_a && data == DAT_KEY_A) ? S_KEY1 : S_IDLE;
        S_KEY1:    st <= (hit_b && data == DAT_KEY_B) ? S_KEY2 : S_IDLE;
        S_KEY2: begin
          if (hit_a && data == DAT_PROG)       st <= S_PROG;
          else if (hit_a && data == DAT_ERASE) st <= S_ER_KEY0;
          else                                 st <= S_IDLE;
        end
        S_ER_KEY0: st <= (hit_a && data == DAT_KEY_A) ? S_ER_KEY1 : S_IDLE;
        S_ER_KEY1: st <= (hit_b && data == DAT_KEY_B) ? S_ER_LAST : S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  AST_SEQ_LOCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    lock |=> (st == S_IDLE)); // R7

endmodule

// File: rtl/fcd_erase_win.sv
module fcd_erase_win #(
  parameter int SECT_W  = 3,
  parameter int WIN_CYC = 16000,
  localparam int NSECT  = 1 << SECT_W,
  localparam int CW     = $clog2(WIN_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add,
  input  logic [SECT_W-1:0] add_sect,
  output logic              win_open,
  output logic              fire,
  output logic [NSECT-1:0]  fire_mask
);

  logic [CW-1:0]    cnt;
  logic [NSECT-1:0] sel_bit;

  always_comb begin
    sel_bit = '0;
    sel_bit[add_sect] = 1'b1;
  end

  assign fire = win_open && (cnt == '0) && !add;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open  <= 1'b0;
      cnt       <= '0;
      fire_mask <= '0;
    end else if (add) begin
      win_open  <= 1'b1;
      cnt       <= CW'(WIN_CYC - 1);
      fire_mask <= (win_open ? fire_mask : '0) | sel_bit;
    end else if (fire) begin
      win_open  <= 1'b0;
    end else if (win_open) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_WIN_RESTART: assert property (@(posedge clk) disable iff (rst)
    add |=> (win_open && cnt == CW'(WIN_CYC - 1))); // R6
  AST_FIRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    fire |=> !win_open); // R6

endmodule

// File: rtl/fcd_engine.sv
module fcd_engine
  import flash_cmd_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int SECT_W    = 3,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_LEN = 256,
  localparam int NSECT    = 1 << SECT_W,
  localparam int DEPTH    = 1 << IDX_W,
  localparam int CW       = $clog2(ERASE_LEN + PROG_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_prog,
  input  logic [IDX_W-1:0] prog_idx,
  input  logic [7:0]       prog_data,
  input  logic             start_erase,
  input  logic [NSECT-1:0] erase_mask,
  input  logic [7:0]       q,
  output logic             busy,
  output logic             poll7,
  output logic [IDX_W-1:0] raddr,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_waddr,
  output logic [7:0]       mem_wdata
);

  eng_state_t       st;
  logic [CW-1:0]    cnt;
  logic [IDX_W-1:0] p_idx;
  logic [7:0]       p_data;
  logic [NSECT-1:0] mask;
  logic [IDX_W-1:0] sweep;
  logic             sweep_on;

  assign busy  = (st != ENG_IDLE);
  assign raddr = p_idx;

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = p_idx;
    mem_wdata = q & p_data;
    if (st == ENG_P_WR) begin
      mem_we = 1'b1;
    end else if (st == ENG_ERASE) begin
      mem_waddr = sweep;
      mem_wdata = 8'hFF;
      mem_we    = sweep_on && mask[sweep[IDX_W-1 -: SECT_W]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ENG_IDLE;
      cnt      <= '0;
      p_idx    <= '0;
      p_data   <= '0;
      mask     <= '0;
      sweep    <= '0;
      sweep_on <= 1'b0;
      poll7    <= 1'b0;
    end else if (st == ENG_IDLE) begin
      if (start_prog) begin
        st     <= ENG_P_RD;
        cnt    <= CW'(PROG_CYC - 1);
        p_idx  <= prog_idx;
        p_data <= prog_data;
        poll7  <= ~prog_data[7];
      end else if (start_erase) begin
        st       <= ENG_ERASE;
        cnt      <= CW'(ERASE_LEN - 1);
        mask     <= erase_mask;
        sweep    <= '0;
        sweep_on <= 1'b1;
        poll7    <= 1'b0;
      end
    end else begin
      cnt <= cnt - 1'b1;
      case (st)
        ENG_P_RD: st <= ENG_P_WR;
        ENG_P_WR: st <= ENG_WAIT;
        ENG_ERASE: begin
          if (sweep_on) begin
            if (sweep == IDX_W'(DEPTH - 1)) sweep_on <= 1'b0;
            else                            sweep    <= sweep + 1'b1;
          end
        end
        default: ;
      endcase
      if (cnt == '0) begin
        st    <= ENG_IDLE;
        poll7 <= 1'b0;
      end
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    (start_prog || start_erase) |-> (st == ENG_IDLE)); // R7
  AST_SWEEP_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == '0 && st == ENG_ERASE) |-> !sweep_on); // R4

endmodule

// File: rtl/fcd_store.sv
module fcd_store #(
  parameter int IDX_W = 7,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       q,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= mem[raddr];
  end

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int SECT_W    = 3,
  parameter int CELL_W    = 4,
  parameter int CLK_HZ    = 200_000_000,
  parameter int WIN_US    = 80,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        rd_data,
  output logic              busy
);

  localparam int IDX_W     = SECT_W + CELL_W;
  localparam int DEPTH     = 1 << IDX_W;
  localparam int NSECT     = 1 << SECT_W;
  localparam int WIN_CYC   = (CLK_HZ / 1_000_000) * WIN_US;
  localparam int ERASE_LEN = (ERASE_CYC > DEPTH + 1) ? ERASE_CYC : DEPTH + 1;

  logic [IDX_W-1:0]  bus_idx, eng_raddr, st_raddr, mem_waddr;
  logic [SECT_W-1:0] bus_sect;
  logic [7:0]        q, mem_wdata, status, stat_q;
  logic              eng_busy, poll7, mem_we, win_open, fire, sel_q;
  logic              start_prog, start_chip, sect_req, add, lock;
  logic [NSECT-1:0]  fire_mask, erase_mask;

  assign bus_sect = bus_addr[ADDR_W-1 -: SECT_W];
  assign bus_idx  = {bus_sect, bus_addr[CELL_W-1:0]};
  assign lock     = eng_busy || win_open;

  fcd_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .lock       (lock),
    .we         (bus_we),
    .cmp_addr   (bus_addr[CMP_W-1:0]),
    .data       (bus_wdata),
    .start_prog (start_prog),
    .start_chip (start_chip),
    .sect_req   (sect_req)
  );

  assign add = sect_req || (win_open && bus_we && bus_wdata == DAT_SECTOR);

  fcd_erase_win #(.SECT_W(SECT_W), .WIN_CYC(WIN_CYC)) u_win (
    .clk       (clk),
    .rst       (rst),
    .add       (add),
    .add_sect  (bus_sect),
    .win_open  (win_open),
    .fire      (fire),
    .fire_mask (fire_mask)
  );

  assign erase_mask = start_chip ? '1 : fire_mask;

  fcd_engine #(
    .IDX_W     (IDX_W),
    .SECT_W    (SECT_W),
    .PROG_CYC  (PROG_CYC),
    .ERASE_LEN (ERASE_LEN)
  ) u_eng (
    .clk         (clk),
    .rst         (rst),
    .start_prog  (start_prog),
    .prog_idx    (bus_idx),
    .prog_data   (bus_wdata),
    .start_erase (start_chip || fire),
    .erase_mask  (erase_mask),
    .q           (q),
    .busy        (eng_busy),
    .poll7       (poll7),
    .raddr       (eng_raddr),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata)
  );

  assign st_raddr = eng_busy ? eng_raddr : bus_idx;

  fcd_store #(.IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .raddr (st_raddr),
    .q     (q),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata)
  );

  assign status = {poll7, 3'b000, win_open, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      sel_q  <= lock;
      stat_q <= status;
    end
  end

  assign rd_data = sel_q ? stat_q : q;
  assign busy    = lock;

  AST_WIN_ENGINE_EXCL: assert property (@(posedge clk) disable iff (rst)
    win_open |-> !eng_busy); // R6
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> eng_busy); // R7

endmodule

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb;

  localparam int ADDR_W = 17;
  localparam int WIN_C  = 200;   // 200 MHz x 1 us

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic [7:0]        rd_data;
  logic              busy;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_if #(.WIN_US(1)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .rd_data   (rd_data),
    .busy      (busy)
  );

  // {address, data to program, expected stored byte}
  localparam logic [32:0] VEC [8] = '{
    {17'h00003, 8'hA5, 8'hA5},
    {17'h00003, 8'h0F, 8'h05},
    {17'h04007, 8'h3C, 8'h3C},
    {17'h1C00F, 8'h81, 8'h81},
    {17'h1C00F, 8'h7E, 8'h00},
    {17'h0800A, 8'h5A, 8'h5A},
    {17'h10001, 8'hC3, 8'hC3},
    {17'h0800A, 8'hFF, 8'h5A}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && busy; g++) idle(1);
    idle(1);
  endtask

  task automatic cmd_prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic cmd_erase(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    idle(3);
    chk("R10 reset busy", {7'd0, busy}, 8'h00);
    chk("R11 reset rd_data", rd_data, 8'h00);
    @(negedge clk) rst = 1'b0;
    idle(2);

    // R4 chip erase, R9 erase status, R10 busy rise
    cmd_erase(17'h05555, 8'h10);
    chk("R10 busy after chip erase", {7'd0, busy}, 8'h01);
    rd(17'h00000, v);
    chk("R9 erase status", v, 8'h00);
    wait_idle();
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 16; c++) begin
        rd({s[2:0], 10'd0, c[3:0]}, v);
        chk("R4 chip erase FF", v, 8'hFF);
      end

    // R2 program table, R9 program status
    for (int i = 0; i < 8; i++) begin
      cmd_prog(VEC[i][32:16], VEC[i][15:8]);
      rd(VEC[i][32:16], v);
      chk("R9 program status", v, VEC[i][15] ? 8'h00 : 8'h80);
      wait_idle();
      rd(VEC[i][32:16], v);
      chk("R2 programmed byte", v, VEC[i][7:0]);
    end

    // R11 back-to-back reads
    rd(17'h00003, v); rd(17'h0800A, v2);
    chk("R11 read A", v, 8'h05);
    chk("R11 read B", v2, 8'h5A);

    // R1 A16/A15 ignored in command addresses
    wr(17'h1D555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h15555, 8'hA0); wr(17'h04009, 8'h66);
    wait_idle();
    rd(17'h04009, v);
    chk("R1 upper bits ignored", v, 8'h66);

    // R1 wrong first address
    wr(17'h05554, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0); wr(17'h04005, 8'h00);
    chk("R1 bad prefix no busy", {7'd0, busy}, 8'h00);
    rd(17'h04005, v);
    chk("R1 bad prefix no write", v, 8'hFF);

    // R8 mismatched second step
    wr(17'h05555, 8'hAA); wr(17'h02AAB, 8'h55); wr(17'h05555, 8'hA0); wr(17'h04005, 8'h00);
    chk("R8 mismatch no busy", {7'd0, busy}, 8'h00);
    rd(17'h04005, v);
    chk("R8 mismatch no write", v, 8'hFF);

    // R3 read/reset
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hF0); wr(17'h04005, 8'h00);
    chk("R3 reset no busy", {7'd0, busy}, 8'h00);
    rd(17'h04005, v);
    chk("R3 reset no write", v, 8'hFF);

    // R7 lockout during program
    cmd_prog(17'h10002, 8'h11);
    cmd_prog(17'h10003, 8'h00);
    wait_idle();
    rd(17'h10002, v);
    chk("R7 first program", v, 8'h11);
    rd(17'h10003, v);
    chk("R7 locked program ignored", v, 8'hFF);

    // R5/R6 sector erase with restart, R7 lockout in window
    cmd_erase(17'h04000, 8'h30);
    chk("R10 busy in window", {7'd0, busy}, 8'h01);
    idle(WIN_C - 20);
    wr(17'h1C123, 8'h30);
    cmd_prog(17'h10004, 8'h00);
    idle(WIN_C - 5);
    rd(17'h00000, v);
    chk("R6 window still open", v, 8'h08);
    rd(17'h00000, v);
    chk("R6 erase started", v, 8'h00);
    chk("R10 busy during erase", {7'd0, busy}, 8'h01);
    wait_idle();
    rd(17'h04007, v);  chk("R5 sector 1 erased", v, 8'hFF);
    rd(17'h04009, v);  chk("R5 sector 1 erased b", v, 8'hFF);
    rd(17'h1C00F, v);  chk("R6 added sector 7 erased", v, 8'hFF);
    rd(17'h00003, v);  chk("R5 sector 0 kept", v, 8'h05);
    rd(17'h0800A, v);  chk("R5 sector 2 kept", v, 8'h5A);
    rd(17'h10001, v);  chk("R5 sector 4 kept", v, 8'hC3);
    rd(17'h10004, v);  chk("R7 window program ignored", v, 8'hFF);
    rd(17'h10002, v);  chk("R9 array read after end", v, 8'h11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule